// File: doc/BRIEF.md
# Direct I/O Address Former

This block forms the 16-bit device address used by the read-direct and write-direct instructions. A command brings the instruction's 17-bit address field, an index flag, an indirect flag, the current index register value and the mapping bit of the status word. Without indirection the address is formed at once. With indexing, the index register value is added to a 17-bit base. The sum wraps inside 17 bits and then keeps only its low 16 bits. The resulting address is never translated.

When indirection is requested, the block first fetches the indirect word over a request/acknowledge port. That fetch uses the address field as its address. It is flagged as mapped or real according to the status mapping bit. The low 17 bits of the returned word become the base, and any indexing is applied to that base. The result appears on the output with a single-cycle strobe.

Commands enter over a valid/ready handshake. `cmd_ready` is low while an indirect fetch is outstanding and during the cycle the strobe is high. A sender must hold `cmd_valid` and all command fields steady until a cycle where both are high. The output has no back-pressure: the strobe is a one-cycle event.

Top module: `dio_addr_former`

## Requirements
- R1: A command with neither index nor indirect flag yields `dio_addr` equal to `cmd_field[15:0]`. `dio_valid` is high in the cycle after acceptance.
- R2: With the index flag set and the indirect flag clear, `dio_addr` is bits 15:0 of (`cmd_field` + `cmd_index_val[16:0]`) taken modulo 2^17. A carry out of bit 16 is dropped and raises no flag.
- R3: With the indirect flag set, `fetch_req` rises in the cycle after acceptance. At that point `fetch_addr` equals `cmd_field` zero-extended to 20 bits, and `fetch_mapped` equals the accepted `cmd_map_en`. All three stay unchanged until a cycle with `fetch_ack` high, and `fetch_req` is low in the following cycle.
- R4: With the indirect flag set and the index flag clear, `dio_addr` equals `fetch_word[15:0]`. `dio_valid` is high in the cycle after the acknowledge.
- R5: With both flags set, `dio_addr` is bits 15:0 of (`fetch_word[16:0]` + index[16:0]) modulo 2^17. The index value used is the one present at acceptance.
- R6: `cmd_map_en` has no effect on `dio_addr`, because the final address is never mapped.
- R7: `dio_valid` is never high for two consecutive cycles. `cmd_ready` is low while `dio_valid` or `fetch_req` is high.
- R8: Bits 31:17 of `cmd_index_val` have no effect on the result.
- R9: After reset, `dio_valid` and `fetch_req` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_field | input | 17 | Instruction address field |
| cmd_index_en | input | 1 | Indexing requested |
| cmd_indirect | input | 1 | Indirection requested |
| cmd_index_val | input | 32 | Index register contents |
| cmd_map_en | input | 1 | Status-word mapping bit |
| fetch_req | output | 1 | Indirect word fetch request |
| fetch_addr | output | 20 | Indirect word address |
| fetch_mapped | output | 1 | Fetch address is virtual (mapped) |
| fetch_ack | input | 1 | Fetch done; `fetch_word` valid |
| fetch_word | input | 32 | Returned indirect word |
| dio_addr | output | 16 | Formed direct I/O address |
| dio_valid | output | 1 | One-cycle strobe for `dio_addr` |

## Verification
The bench builds the block with its default widths: a 17-bit field, a 16-bit result, 32-bit index and memory words, and 20-bit fetch addresses. With these widths the stimulus can reach a carry out of bit 16 and a sum that crosses from bit 15 into bit 16. It can also set index bits above 16 and indirect-word bits above 16, all of which must vanish from the result. Back-to-back commands and acknowledge delays of several cycles exercise the ready stall and the holding of the fetch request.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } dio_state_e;
endpackage

// File: rtl/dio_index_add.sv
module dio_index_add #(
  parameter int FIELD_W = 17,
  parameter int OUT_W   = 16,
  parameter int IDX_W   = 32
) (
  input  logic [FIELD_W-1:0] base,
  input  logic [IDX_W-1:0]   index,
  input  logic               index_en,
  output logic [OUT_W-1:0]   addr
);
  logic [FIELD_W-1:0] idx_f;
  logic [FIELD_W-1:0] sum;

  // Narrow or widen the index to the field width
  generate
    if (IDX_W > FIELD_W) begin : g_idx_narrow
      logic unused_idx_hi;
      assign unused_idx_hi = ^index[IDX_W-1:FIELD_W];
      assign idx_f = index[FIELD_W-1:0];
    end else if (IDX_W == FIELD_W) begin : g_idx_same
      assign idx_f = index;
    end else begin : g_idx_wide
      assign idx_f = {{(FIELD_W-IDX_W){1'b0}}, index};
    end
  endgenerate

  // Sum held in FIELD_W bits: carry out of the top bit is lost
  always_comb begin
    sum = base;
    if (index_en) sum = base + idx_f;
  end

  generate
    if (FIELD_W > OUT_W) begin : g_trunc
      logic unused_sum_hi;
      assign unused_sum_hi = ^sum[FIELD_W-1:OUT_W];
      assign addr = sum[OUT_W-1:0];
    end else begin : g_full
      assign addr = sum;
    end
  endgenerate
endmodule

// File: rtl/dio_fetch_ctrl.sv
module dio_fetch_ctrl
  import dio_pkg::*;
#(
  parameter int FIELD_W = 17,
  parameter int PHYS_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FIELD_W-1:0] field,
  input  logic               map_en,
  input  logic               ack,
  output logic               busy,
  output logic               req,
  output logic [PHYS_W-1:0]  addr,
  output logic               mapped,
  output logic               done
);
  dio_state_e         state;
  logic [FIELD_W-1:0] addr_q;
  logic               mapped_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      addr_q   <= '0;
      mapped_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_FETCH;
          addr_q   <= field;
          mapped_q <= map_en;
        end
        ST_FETCH: if (ack) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req    = (state == ST_FETCH);
  assign busy   = req;
  assign done   = req && ack;
  assign mapped = mapped_q;

  generate
    if (PHYS_W > FIELD_W) begin : g_pad
      assign addr = {{(PHYS_W-FIELD_W){1'b0}}, addr_q};
    end else begin : g_nopad
      assign addr = addr_q[PHYS_W-1:0];
    end
  endgenerate

  assert_req_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !req) |=> req);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (req && $stable(addr) && $stable(mapped)));
  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack) |=> !req);
endmodule

// File: rtl/dio_addr_former.sv
module dio_addr_former #(
  parameter int FIELD_W = 17,
  parameter int OUT_W   = 16,
  parameter int IDX_W   = 32,
  parameter int WORD_W  = 32,
  parameter int PHYS_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [FIELD_W-1:0] cmd_field,
  input  logic               cmd_index_en,
  input  logic               cmd_indirect,
  input  logic [IDX_W-1:0]   cmd_index_val,
  input  logic               cmd_map_en,
  output logic               fetch_req,
  output logic [PHYS_W-1:0]  fetch_addr,
  output logic               fetch_mapped,
  input  logic               fetch_ack,
  input  logic [WORD_W-1:0]  fetch_word,
  output logic [OUT_W-1:0]   dio_addr,
  output logic               dio_valid
);
  logic               busy;
  logic               done;
  logic               accept;
  logic               idx_en_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FIELD_W-1:0] word_base;
  logic [FIELD_W-1:0] base_sel;
  logic [IDX_W-1:0]   idx_sel;
  logic               idx_en_sel;
  logic [OUT_W-1:0]   formed;

  assign cmd_ready = !busy && !dio_valid;
  assign accept    = cmd_valid && cmd_ready;

  generate
    if (WORD_W > FIELD_W) begin : g_word_narrow
      logic unused_word_hi;
      assign unused_word_hi = ^fetch_word[WORD_W-1:FIELD_W];
      assign word_base = fetch_word[FIELD_W-1:0];
    end else if (WORD_W == FIELD_W) begin : g_word_same
      assign word_base = fetch_word;
    end else begin : g_word_wide
      assign word_base = {{(FIELD_W-WORD_W){1'b0}}, fetch_word};
    end
  endgenerate

  // Index state captured at acceptance for the indirect path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_en_q <= 1'b0;
      idx_q    <= '0;
    end else if (accept && cmd_indirect) begin
      idx_en_q <= cmd_index_en;
      idx_q    <= cmd_index_val;
    end
  end

  always_comb begin
    if (busy) begin
      base_sel   = word_base;
      idx_sel    = idx_q;
      idx_en_sel = idx_en_q;
    end else begin
      base_sel   = cmd_field;
      idx_sel    = cmd_index_val;
      idx_en_sel = cmd_index_en;
    end
  end

  dio_index_add #(.FIELD_W(FIELD_W), .OUT_W(OUT_W), .IDX_W(IDX_W)) u_add (
    .base     (base_sel),
    .index    (idx_sel),
    .index_en (idx_en_sel),
    .addr     (formed)
  );

  dio_fetch_ctrl #(.FIELD_W(FIELD_W), .PHYS_W(PHYS_W)) u_fetch (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept && cmd_indirect),
    .field  (cmd_field),
    .map_en (cmd_map_en),
    .ack    (fetch_ack),
    .busy   (busy),
    .req    (fetch_req),
    .addr   (fetch_addr),
    .mapped (fetch_mapped),
    .done   (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dio_valid <= 1'b0;
      dio_addr  <= '0;
    end else begin
      dio_valid <= (accept && !cmd_indirect) || done;
      if ((accept && !cmd_indirect) || done) dio_addr <= formed;
    end
  end

  assert_direct_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_indirect) |=> dio_valid);
  assert_plain_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_indirect && !cmd_index_en) |=> (dio_addr == $past(cmd_field[OUT_W-1:0])));
  assert_fetch_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_indirect) |=> (fetch_addr[FIELD_W-1:0] == $past(cmd_field)
                                  && fetch_mapped == $past(cmd_map_en)));
  assert_indirect_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack) |=> dio_valid);
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dio_valid |=> !dio_valid);
endmodule

// File: tb/sim_dio_addr_former.sv
module sim_dio_addr_former;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [16:0] cmd_field = '0;
  logic        cmd_index_en = 1'b0;
  logic        cmd_indirect = 1'b0;
  logic [31:0] cmd_index_val = '0;
  logic        cmd_map_en = 1'b0;
  logic        fetch_req;
  logic [19:0] fetch_addr;
  logic        fetch_mapped;
  logic        fetch_ack = 1'b0;
  logic [31:0] fetch_word = '0;
  logic [15:0] dio_addr;
  logic        dio_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done_all = 1'b0;
  bit prev_valid = 1'b0;

  typedef struct { logic [15:0] addr; int when; int rq; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dio_addr_former u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_field(cmd_field), .cmd_index_en(cmd_index_en), .cmd_indirect(cmd_indirect),
    .cmd_index_val(cmd_index_val), .cmd_map_en(cmd_map_en), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_mapped(fetch_mapped), .fetch_ack(fetch_ack),
    .fetch_word(fetch_word), .dio_addr(dio_addr), .dio_valid(dio_valid)
  );

  task automatic check(input bit ok, input int rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=0x%0h expected=0x%0h at cycle %0d", rq, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] model(input logic [16:0] field, input bit ix,
                                        input bit ind, input logic [31:0] iv,
                                        input logic [31:0] word);
    logic [31:0] b;
    b = ind ? (word & 32'h1FFFF) : {15'd0, field};
    if (ix) b = b + (iv & 32'h1FFFF);
    return b[15:0];
  endfunction

  // Driver: offers one command, serves the fetch, pushes the expectation
  task automatic send(input logic [16:0] field, input bit ix, input bit ind,
                      input logic [31:0] iv, input bit mp, input logic [31:0] word,
                      input int dly, input int rq);
    exp_t e;
    @(negedge clk);
    cmd_field = field; cmd_index_en = ix; cmd_indirect = ind;
    cmd_index_val = iv; cmd_map_en = mp; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    e.addr = model(field, ix, ind, iv, word);
    e.rq = rq;
    if (!ind) begin
      e.when = cyc + 1;
      sb.push_back(e);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_index_val = 32'hDEAD_BEEF;  // R5: later index changes must not matter
    cmd_field = ~field;
    cmd_map_en = ~mp;
    if (ind) begin
      check(fetch_req == 1'b1, 3, fetch_req, 1);
      check(fetch_addr == {3'b000, field}, 3, fetch_addr, {3'b000, field});
      check(fetch_mapped == mp, 3, fetch_mapped, mp);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        check(fetch_req && fetch_addr == {3'b000, field} && fetch_mapped == mp,
              3, fetch_addr, {3'b000, field});
      end
      fetch_word = word; fetch_ack = 1'b1;
      e.when = cyc + 1;
      sb.push_back(e);
      @(negedge clk);
      fetch_ack = 1'b0; fetch_word = 32'h0;
      check(fetch_req == 1'b0, 3, fetch_req, 0);
    end
  endtask

  // Monitor: compares every strobe against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (dio_valid) begin
        // R7: strobe lasts one cycle and stalls the command port
        check(!prev_valid, 7, prev_valid, 0);
        check(!cmd_ready, 7, cmd_ready, 0);
        if (sb.size() == 0) begin
          check(1'b0, 7, dio_addr, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(dio_addr == e.addr, e.rq, dio_addr, e.addr);
          check(cyc == e.when, e.rq, cyc, e.when);
        end
      end
      if (fetch_req) check(!cmd_ready, 7, cmd_ready, 0);
      prev_valid <= dio_valid;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!dio_valid, 9, dio_valid, 0);
    check(!fetch_req, 9, fetch_req, 0);
    check(cmd_ready, 9, cmd_ready, 1);

    send(17'h1ABCD, 0, 0, 32'h0, 0, 32'h0, 0, 1);          // R1
    send(17'h00042, 0, 0, 32'h7, 1, 32'h0, 0, 1);          // R1 index value ignored when off
    send(17'h01000, 1, 0, 32'h234, 0, 32'h0, 0, 2);        // R2 plain sum
    send(17'h1FFFF, 1, 0, 32'h2, 0, 32'h0, 0, 2);          // R2 carry out of bit 16
    send(17'h0FFFF, 1, 0, 32'h1, 0, 32'h0, 0, 2);          // R2 sum lands in bit 16 only
    send(17'h00010, 1, 0, 32'hFFFE0005, 0, 32'h0, 0, 8);   // R8 high index bits dropped
    send(17'h00321, 0, 1, 32'h0, 1, 32'hFFF2BEEF, 3, 4);   // R4 mapped fetch
    send(17'h1F00F, 0, 1, 32'h0, 0, 32'h0000_1234, 0, 4);  // R4 real fetch, immediate ack
    send(17'h00400, 1, 1, 32'h20, 1, 32'h0001FFF0, 2, 5);  // R5 wrap after indirect
    send(17'h00401, 1, 1, 32'hFFFF_0100, 0, 32'hABCD_0011, 5, 5); // R5 and R8
    send(17'h12345, 1, 0, 32'h111, 0, 32'h0, 0, 6);        // R6 map off
    send(17'h12345, 1, 0, 32'h111, 1, 32'h0, 0, 6);        // R6 map on, same result
    send(17'h00777, 1, 1, 32'h1, 0, 32'h0000_8000, 1, 6);  // R6 real fetch
    send(17'h00777, 1, 1, 32'h1, 1, 32'h0000_8000, 1, 6);  // R6 mapped fetch
    repeat (4) @(negedge clk);
    check(sb.size() == 0, 7, sb.size(), 0);
    done_all = 1'b1;
  end

  initial begin
    wait (done_all || cyc > 20000);
    if (!done_all) begin
      checks++; fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", cyc, 20000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule